// File: doc/BRIEF.md
# Configuration Source Selector with Held Tag Bit

This block produces a 5-bit configuration word and a single tag bit for downstream logic that needs a preset setting, such as a regulator code or a board strap value. The word is taken from one of three places: five external input pins, the low five bits of stored register A, or the low five bits of stored register B. Both stored registers are 6 bits wide, and their top bit (bit 5) is the tag.

Two external select pins choose the source. A bus-side controller can load an override that forces a source no matter what the pins say, and can later release it. The tag output passes bit 5 of the selected stored register while select pin 0 is low, and keeps its last value while select pin 0 is high.

Select and data pins are synchronized with two flops before use. The stored-register inputs are taken to be quasi-static values from storage and are used directly. Both outputs are registered.

Top module: `cfg_route_latch`

## Requirements
- R1: While reset is asserted, and in the first sampled state after it, `cfg_out` is 0 and `tag_out` is 0. The override is cleared, so selection follows the pins.
- R2: With no override active and `sel1_pin` low, `cfg_out` equals `store_b[4:0]`, whatever `sel0_pin` is.
- R3: With no override active, `sel1_pin` high and `sel0_pin` low, `cfg_out` equals `pin_val`.
- R4: With no override active and both select pins high, `cfg_out` equals `store_a[4:0]`.
- R5: A pulse on `ovr_wr` with `ovr_on`=1 and `ovr_code` 2'b00, 2'b01 or 2'b10 forces the source to the pins, register A or register B respectively, whatever the select pins are.
- R6: A pulse on `ovr_wr` with `ovr_on`=0 releases the override, and selection returns to the pins.
- R7: A pulse on `ovr_wr` with `ovr_on`=1 and `ovr_code`=2'b11 is ignored: the previous override state, active or not, and its source stay in force.
- R8: While `sel0_pin` is low, `tag_out` follows bit 5 of register B when register B is the active source, and bit 5 of register A otherwise.
- R9: While `sel0_pin` is high, `tag_out` keeps its value even when the stored registers or the selection change.
- R10: With register B all zeros, no override, and `sel1_pin` low, `cfg_out` is 0. With `sel0_pin` also low, `tag_out` is 0. This lets select pin 1 act as a force-to-default input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel0_pin | input | 1 | Select pin 0; also holds the tag when high |
| sel1_pin | input | 1 | Select pin 1 |
| pin_val | input | 5 | External configuration pins |
| store_a | input | 6 | Stored register A (bit 5 is the tag) |
| store_b | input | 6 | Stored register B (bit 5 is the tag) |
| ovr_wr | input | 1 | One-cycle strobe that loads the override command |
| ovr_on | input | 1 | Command: 1 forces a source, 0 releases the override |
| ovr_code | input | 2 | Forced source: 00 pins, 01 register A, 10 register B, 11 reserved |
| cfg_out | output | 5 | Selected configuration word |
| tag_out | output | 1 | Tag bit, transparent while sel0 is low |

## Verification
Random rounds draw unrelated values for the pins and for both stored registers, so each of the three sources gives a different word and a wrong choice of source shows up at once. Each round first changes the data with the selects held, then changes the selects with the data held. This separates a tag that is correctly held from one that follows new data, and it shows which register the tag is taken from. Override commands are mixed in at random, including the reserved code and releases. Directed cases cover the reset state, a reserved write while an override is active, and the default behaviour with register B zeroed.

// File: rtl/cfg_route_pkg.sv
// Package: shared source encoding for the configuration selector.
// Assumes: code 2'b11 is reserved and is never stored as a forced source.
package cfg_route_pkg;
    typedef enum logic [1:0] {
        SRC_PINS = 2'b00,
        SRC_REGA = 2'b01,
        SRC_REGB = 2'b10
    } src_t;

    localparam logic [1:0] CODE_RESERVED = 2'b11;
endpackage

// File: rtl/cfg_sync.sv
// Module: cfg_sync
// Multi-stage flop synchronizer for a bundle of slow, independent pins.
// Assumes: each bit is quasi-static, so bits may settle on different cycles.
module cfg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    // Shift the sampled pins through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cfg_ovr_reg.sv
// Module: cfg_ovr_reg
// Holds the bus-side override: an active flag plus a 2-bit forced source.
// Assumes: ovr_wr is a single-cycle strobe; the reserved code is dropped.
module cfg_ovr_reg
    import cfg_route_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ovr_wr,
    input  logic       ovr_on,
    input  logic [1:0] ovr_code,
    output logic       act_q,
    output logic [1:0] code_q
);
    // Apply release or force commands; ignore the reserved code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            code_q <= SRC_PINS;
        end else if (ovr_wr) begin
            if (!ovr_on) begin
                act_q <= 1'b0;
            end else if (ovr_code != CODE_RESERVED) begin
                act_q  <= 1'b1;
                code_q <= ovr_code;
            end
        end
    end
endmodule

// File: rtl/cfg_src_sel.sv
// Module: cfg_src_sel
// Decides the active source from synchronized pins or the held override.
// Assumes: pin decode is sel1=0 -> B, sel1=1/sel0=0 -> pins, both 1 -> A.
module cfg_src_sel
    import cfg_route_pkg::*;
(
    input  logic [1:0] sel_s,
    input  logic       ovr_act,
    input  logic [1:0] ovr_code,
    output src_t       src
);
    // Pick the override source when active, otherwise decode the pins.
    always_comb begin
        if (ovr_act) begin
            case (ovr_code)
                2'b01:   src = SRC_REGA;
                2'b10:   src = SRC_REGB;
                default: src = SRC_PINS;
            endcase
        end else if (!sel_s[1]) begin
            src = SRC_REGB;
        end else if (!sel_s[0]) begin
            src = SRC_PINS;
        end else begin
            src = SRC_REGA;
        end
    end
endmodule

// File: rtl/cfg_out_stage.sv
// Module: cfg_out_stage
// Registers the selected word and the tag bit; the tag flop has a level
// enable that models a transparent latch in the synchronous domain.
// Assumes: the tag comes from register A whenever register B is not selected.
module cfg_out_stage
    import cfg_route_pkg::*;
#(
    parameter int BUS_W = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  src_t           src,
    input  logic [BUS_W-1:0] pin_s,
    input  logic [BUS_W:0] reg_a,
    input  logic [BUS_W:0] reg_b,
    input  logic           hold,
    output logic [BUS_W-1:0] bus_q,
    output logic           tag_q
);
    logic [BUS_W-1:0] bus_d;
    logic             tag_d;

    // Route the chosen source onto the word and pick the tag bit.
    always_comb begin
        case (src)
            SRC_REGA: bus_d = reg_a[BUS_W-1:0];
            SRC_REGB: bus_d = reg_b[BUS_W-1:0];
            default:  bus_d = pin_s;
        endcase
        tag_d = (src == SRC_REGB) ? reg_b[BUS_W] : reg_a[BUS_W];
    end

    // Register the word every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_d;
    end

    // Update the tag only while the hold pin is low.
    always_ff @(posedge clk) begin
        if (!rst_n)     tag_q <= 1'b0;
        else if (!hold) tag_q <= tag_d;
    end
endmodule

// File: rtl/cfg_route_latch.sv
// Module: cfg_route_latch (top)
// Three-way configuration selector with a bus-side override and a held
// tag bit. Assumes the stored registers are stable storage outputs.
module cfg_route_latch
    import cfg_route_pkg::*;
#(
    parameter int BUS_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel0_pin,
    input  logic             sel1_pin,
    input  logic [BUS_W-1:0] pin_val,
    input  logic [BUS_W:0]   store_a,
    input  logic [BUS_W:0]   store_b,
    input  logic             ovr_wr,
    input  logic             ovr_on,
    input  logic [1:0]       ovr_code,
    output logic [BUS_W-1:0] cfg_out,
    output logic             tag_out
);
    logic [1:0]       sel_s;
    logic [BUS_W-1:0] pin_s;
    logic             ovr_act;
    logic [1:0]       ovr_code_q;
    src_t             src;

    cfg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync_sel (
        .clk(clk), .rst_n(rst_n), .d({sel1_pin, sel0_pin}), .q(sel_s)
    );

    cfg_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync_pin (
        .clk(clk), .rst_n(rst_n), .d(pin_val), .q(pin_s)
    );

    cfg_ovr_reg u_ovr (
        .clk(clk), .rst_n(rst_n), .ovr_wr(ovr_wr), .ovr_on(ovr_on),
        .ovr_code(ovr_code), .act_q(ovr_act), .code_q(ovr_code_q)
    );

    cfg_src_sel u_sel (
        .sel_s(sel_s), .ovr_act(ovr_act), .ovr_code(ovr_code_q), .src(src)
    );

    cfg_out_stage #(.BUS_W(BUS_W)) u_out (
        .clk(clk), .rst_n(rst_n), .src(src), .pin_s(pin_s),
        .reg_a(store_a), .reg_b(store_b), .hold(sel_s[0]),
        .bus_q(cfg_out), .tag_q(tag_out)
    );
endmodule

// File: rtl/cfg_route_latch_chk.sv
// Module: cfg_route_latch_chk
// Checker bound to the top; watches synchronized selects and override state.
module cfg_route_latch_chk #(
    parameter int BUS_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       sel_s,
    input logic [BUS_W-1:0] pin_s,
    input logic             ovr_act,
    input logic [1:0]       ovr_code_q,
    input logic             ovr_wr,
    input logic             ovr_on,
    input logic [1:0]       ovr_code,
    input logic [BUS_W:0]   store_a,
    input logic [BUS_W:0]   store_b,
    input logic [BUS_W-1:0] cfg_out,
    input logic             tag_out
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (cfg_out == '0 && tag_out == 1'b0 && !ovr_act)); // R1
    AST_PIN_REGB: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_act && !sel_s[1]) |=> cfg_out == $past(store_b[BUS_W-1:0])); // R2
    AST_PIN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_act && sel_s == 2'b10) |=> cfg_out == $past(pin_s)); // R3
    AST_PIN_REGA: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_act && sel_s == 2'b11) |=> cfg_out == $past(store_a[BUS_W-1:0])); // R4
    AST_OVR_REGA: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_act && ovr_code_q == 2'b01) |=> cfg_out == $past(store_a[BUS_W-1:0])); // R5
    AST_OVR_REGB: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_act && ovr_code_q == 2'b10) |=> cfg_out == $past(store_b[BUS_W-1:0])); // R5
    AST_OVR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_wr && !ovr_on) |=> !ovr_act); // R6
    AST_OVR_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_wr && ovr_on && ovr_code == 2'b11) |=> ($stable(ovr_act) && $stable(ovr_code_q))); // R7
    AST_TAG_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_s[0] |=> tag_out == $past(
            (ovr_act ? ovr_code_q == 2'b10 : !sel_s[1]) ? store_b[BUS_W] : store_a[BUS_W])); // R8
    AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s[0] |=> $stable(tag_out)); // R9
endmodule

bind cfg_route_latch cfg_route_latch_chk #(.BUS_W(BUS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .pin_s(pin_s),
    .ovr_act(ovr_act), .ovr_code_q(ovr_code_q), .ovr_wr(ovr_wr),
    .ovr_on(ovr_on), .ovr_code(ovr_code), .store_a(store_a),
    .store_b(store_b), .cfg_out(cfg_out), .tag_out(tag_out)
);

// File: tb/tb_cfg_route_latch.sv
// Bench for cfg_route_latch: seeded random rounds plus directed corners.
module tb_cfg_route_latch;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 4;
    localparam int ROUNDS     = 80;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sel0_pin, sel1_pin;
    logic [4:0] pin_val;
    logic [5:0] store_a, store_b;
    logic       ovr_wr, ovr_on;
    logic [1:0] ovr_code;
    logic [4:0] cfg_out;
    logic       tag_out;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    // Bench-side model state
    bit       m_act  = 0;
    bit [1:0] m_code = 2'b00;
    bit       m_tag  = 0;

    cfg_route_latch dut (
        .clk(clk), .rst_n(rst_n), .sel0_pin(sel0_pin), .sel1_pin(sel1_pin),
        .pin_val(pin_val), .store_a(store_a), .store_b(store_b),
        .ovr_wr(ovr_wr), .ovr_on(ovr_on), .ovr_code(ovr_code),
        .cfg_out(cfg_out), .tag_out(tag_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // 0 pins, 1 register A, 2 register B
    function automatic int exp_src();
        if (m_act) return (m_code == 2'b01) ? 1 : (m_code == 2'b10) ? 2 : 0;
        if (!sel1_pin) return 2;
        if (!sel0_pin) return 0;
        return 1;
    endfunction

    function automatic logic [4:0] exp_word();
        case (exp_src())
            1:       return store_a[4:0];
            2:       return store_b[4:0];
            default: return pin_val;
        endcase
    endfunction

    function automatic string word_req();
        if (m_act) return "R5";
        if (!sel1_pin) return "R2";
        if (!sel0_pin) return "R3";
        return "R4";
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
        if (!sel0_pin) m_tag = (exp_src() == 2) ? store_b[5] : store_a[5];
    endtask

    task automatic check_all(input string tag_req_hint);
        chk(word_req(), cfg_out, exp_word());
        chk(sel0_pin ? "R9" : tag_req_hint, tag_out, m_tag);
    endtask

    task automatic send_ovr(input bit on, input bit [1:0] code);
        @(negedge clk);
        ovr_wr = 1'b1; ovr_on = on; ovr_code = code;
        @(negedge clk);
        ovr_wr = 1'b0;
        if (!on) m_act = 0;
        else if (code != 2'b11) begin m_act = 1; m_code = code; end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; sel0_pin = 1'b0; sel1_pin = 1'b1; pin_val = 5'h15;
        store_a = 6'h2A; store_b = 6'h3C; ovr_wr = 1'b0; ovr_on = 1'b0;
        ovr_code = 2'b00;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", cfg_out, 0);
        chk("R1", tag_out, 0);
        rst_n = 1'b1;
        settle();
        check_all("R8");

        // R7: reserved code while an override is active keeps register A
        send_ovr(1'b1, 2'b01);
        settle();
        check_all("R8");
        send_ovr(1'b1, 2'b11);
        settle();
        chk("R7", cfg_out, store_a[4:0]);
        // R6: release returns to pins (sel1=1, sel0=0 -> pins)
        send_ovr(1'b0, 2'b10);
        settle();
        chk("R6", cfg_out, pin_val);

        // R10: register B zero, sel1 low, sel0 low -> zero word and tag
        store_b = 6'h00; sel1_pin = 1'b0; sel0_pin = 1'b0;
        settle();
        chk("R10", cfg_out, 0);
        chk("R10", tag_out, 0);

        // R9: hold with sel0 high; changing stores must not move the tag
        store_b = 6'h20; store_a = 6'h20;
        settle();
        chk("R8", tag_out, 1);
        sel0_pin = 1'b1; sel1_pin = 1'b1;
        settle();
        store_a = 6'h00; store_b = 6'h00;
        settle();
        chk("R9", tag_out, 1);

        // Random rounds: data phase, then select phase
        for (int r = 0; r < ROUNDS; r++) begin
            pin_val = 5'($urandom);
            store_a = 6'($urandom);
            store_b = 6'($urandom);
            if (($urandom % 3) == 0)
                send_ovr(($urandom % 4) != 0, 2'($urandom));
            settle();
            check_all("R8");
            sel0_pin = 1'($urandom);
            sel1_pin = 1'($urandom);
            settle();
            check_all("R8");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule